// File: doc/BRIEF.md
# Flash Blank-Check Engine

This block decides whether a region of on-chip flash is erased. Software gives a byte start address and a 3-bit size code through a small word-wide register port, then issues a check command. The engine reads the array one 64-bit double word per access through a synchronous read port with one cycle of latency. It reports whether every byte it read was 0xFF.

Before any read is issued, the requested range is screened. A misaligned start or a range that touches a write-protected page is rejected with an error flag. A range that runs past the end of the array is also rejected. Scanning stops at the first double word that is not erased. Completion raises a sticky end flag that software clears by writing 1, and it can drive an interrupt. The configuration fields stay locked after reset until a two-word key is written.

Top module: `bscan_blank_check`

## Requirements
- R1: After reset, CTRL (offset 0x8) reads 0x0000_0080 (lock bit 7 set), STAT (offset 0x4) reads 0, ADDR (offset 0xC) reads 0 and irq is 0.
- R2: Writing 0x45670123 and then 0xCDEF89AB as two consecutive writes to KEY (offset 0x0) clears the lock bit. Any other order or any intervening key word leaves it set. Writing CTRL with bit 7 = 1 sets the lock again.
- R3: While the lock bit is 1, a CTRL write does not change the command bit (bit 0), the interrupt enable (bit 2) or the size code (bits 31:29), and it starts no check.
- R4: Only 32-bit accesses (bus_size = 2'b10) take effect. A write of another size is ignored, and a read of another size returns 0.
- R5: A check starts when CTRL is written with bit 0 and bit 1 both 1, while unlocked and idle. Bit 1 always reads 0, and STAT bit 0 (busy) is 1 while the check runs.
- R6: A check reads 2^size double words, starting at double-word index ADDR>>3 and going upward one index at a time. Only one read is outstanding at a time.
- R7: STAT bit 4 reads 0 when every byte read equals 0xFF and 1 otherwise. The scan ends at the first double word that is not erased. The bit is cleared when a check is accepted, and it is otherwise stable while idle.
- R8: When a check finishes, busy returns to 0 and STAT bit 1 (end) is set. Writing 1 to STAT bit 1 clears it, and writing 0 has no effect.
- R9: wp_pages carries one bit per page of PAGE_DW double words. A check whose range touches a protected page, or runs past the last double word, sets STAT bit 2, issues no read and leaves busy at 0. Writing 1 to STAT bit 2 clears it.
- R10: A check requested with ADDR bits 2:0 not zero sets STAT bit 3 and issues no read. This takes priority over the protection check. Writing 1 to STAT bit 3 clears it.
- R11: While CTRL bit 2 is 1 and the end flag is 1, irq stays high. It drops once the end flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_size | input | 2 | Access size, 2'b10 = 32-bit |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational |
| wp_pages | input | FLASH_DW/PAGE_DW | Write-protect bit per page |
| mem_re | output | 1 | Array read request |
| mem_addr | output | log2(FLASH_DW) | Double-word index to read |
| mem_rdata | input | 64 | Array data, valid the cycle after mem_re |
| irq | output | 1 | End-of-check interrupt |

## Verification
The bench builds the engine with a 256-double-word array, pages of 16 double words and the capture register on the read data enabled. With these values the largest size code covers half the array. That lets a 128-read scan end exactly on the last index, and lets another scan from index 200 overrun the end. The small page count keeps protected and adjacent unprotected ranges easy to place. The enabled capture stage exercises the three-cycle read and check loop.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
   localparam logic [31:0] KEY_FIRST  = 32'h4567_0123;
   localparam logic [31:0] KEY_SECOND = 32'hCDEF_89AB;

   localparam logic [3:0] OFS_KEY  = 4'h0;
   localparam logic [3:0] OFS_STAT = 4'h4;
   localparam logic [3:0] OFS_CTRL = 4'h8;
   localparam logic [3:0] OFS_ADDR = 4'hC;
   localparam logic [1:0] SZ_WORD  = 2'b10;

   localparam int CB_CMD  = 0;
   localparam int CB_GO   = 1;
   localparam int CB_IE   = 2;
   localparam int CB_LOCK = 7;

   localparam int SB_BUSY  = 0;
   localparam int SB_END   = 1;
   localparam int SB_PROT  = 2;
   localparam int SB_ALIGN = 3;
   localparam int SB_RES   = 4;

   typedef enum logic [1:0] {SC_IDLE, SC_READ, SC_WAIT, SC_CHECK} scan_st_t;
endpackage

// File: rtl/bscan_key.sv
module bscan_key import bscan_pkg::*; (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        key_wr,
   input  logic [31:0] key_data,
   output logic        unlock
);
   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      armed_q <= 1'b0;
      else if (key_wr) armed_q <= (key_data == KEY_FIRST);
   end

   assign unlock = key_wr && armed_q && (key_data == KEY_SECOND);

   AST_KEY_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      unlock |=> !armed_q); // R2
endmodule

// File: rtl/bscan_guard.sv
module bscan_guard #(
   parameter int FLASH_DW = 1024,
   parameter int PAGE_DW  = 16,
   parameter int LEN_W    = 3,
   localparam int DWA_W   = $clog2(FLASH_DW),
   localparam int NPAGE   = FLASH_DW / PAGE_DW
) (
   input  logic [DWA_W-1:0] start_dw,
   input  logic [LEN_W-1:0] len_code,
   input  logic [NPAGE-1:0] wp,
   output logic             blocked
);
   localparam int PG_SH  = $clog2(PAGE_DW);
   localparam int CALC_W = DWA_W + (2**LEN_W) + 1;

   logic [CALC_W-1:0] span, last_dw, first_pg, last_pg;
   logic [NPAGE-1:0]  touch;
   logic              overrun;

   assign span     = CALC_W'(1) << len_code;
   assign last_dw  = CALC_W'(start_dw) + span - CALC_W'(1);
   assign overrun  = last_dw >= CALC_W'(FLASH_DW);
   assign first_pg = CALC_W'(start_dw) >> PG_SH;
   assign last_pg  = last_dw >> PG_SH;

   for (genvar p = 0; p < NPAGE; p++) begin : g_page
      assign touch[p] = wp[p] && (CALC_W'(p) >= first_pg) && (CALC_W'(p) <= last_pg);
   end

   assign blocked = overrun | (|touch);

   initial begin
      AST_CFG_PAGE_POW2: assert (PAGE_DW >= 1 && (PAGE_DW & (PAGE_DW - 1)) == 0)
         else $error("PAGE_DW must be a power of two");
      AST_CFG_PAGE_FIT: assert (FLASH_DW % PAGE_DW == 0 && NPAGE >= 1)
         else $error("FLASH_DW must hold whole pages");
   end
endmodule

// File: rtl/bscan_engine.sv
module bscan_engine import bscan_pkg::*; #(
   parameter int FLASH_DW = 1024,
   parameter int LEN_W    = 3,
   parameter int DATA_W   = 64,
   parameter bit IN_REG   = 1'b1,
   localparam int DWA_W   = $clog2(FLASH_DW)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DWA_W-1:0]  start_dw,
   input  logic [LEN_W-1:0]  len_code,
   output logic              mem_re,
   output logic [DWA_W-1:0]  mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              busy,
   output logic              done,
   output logic              dirty
);
   localparam int CNT_W = 2**LEN_W;

   scan_st_t          st_q;
   logic [DWA_W-1:0]  addr_q;
   logic [CNT_W-1:0]  left_q;
   logic [DATA_W-1:0] chk_data;
   logic              is_blank, last_one;

   if (IN_REG) begin : g_capture
      logic [DATA_W-1:0] cap_q;
      always_ff @(posedge clk) cap_q <= mem_rdata;
      assign chk_data = cap_q;
   end else begin : g_direct
      assign chk_data = mem_rdata;
   end

   assign is_blank = &chk_data;
   assign last_one = (left_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SC_IDLE;
         addr_q <= '0;
         left_q <= '0;
      end else begin
         unique case (st_q)
            SC_IDLE: if (start) begin
               addr_q <= start_dw;
               left_q <= (CNT_W'(1) << len_code) - CNT_W'(1);
               st_q   <= SC_READ;
            end
            SC_READ: st_q <= IN_REG ? SC_WAIT : SC_CHECK;
            SC_WAIT: st_q <= SC_CHECK;
            SC_CHECK: begin
               if (!is_blank || last_one) st_q <= SC_IDLE;
               else begin
                  addr_q <= addr_q + DWA_W'(1);
                  left_q <= left_q - CNT_W'(1);
                  st_q   <= SC_READ;
               end
            end
            default: st_q <= SC_IDLE;
         endcase
      end
   end

   assign mem_re   = (st_q == SC_READ);
   assign mem_addr = addr_q;
   assign busy     = (st_q != SC_IDLE);
   assign done     = (st_q == SC_CHECK) && (!is_blank || last_one);
   assign dirty    = (st_q == SC_CHECK) && !is_blank;

   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |=> !mem_re); // R6
   AST_DIRTY_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      dirty |=> !busy); // R7
   AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy); // R5
endmodule

// File: rtl/bscan_blank_check.sv
module bscan_blank_check import bscan_pkg::*; #(
   parameter int FLASH_DW = 1024,
   parameter int PAGE_DW  = 16,
   parameter int LEN_W    = 3,
   parameter bit IN_REG   = 1'b1,
   localparam int DWA_W   = $clog2(FLASH_DW),
   localparam int NPAGE   = FLASH_DW / PAGE_DW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [3:0]       bus_addr,
   input  logic [1:0]       bus_size,
   input  logic [31:0]      bus_wdata,
   output logic [31:0]      bus_rdata,
   input  logic [NPAGE-1:0] wp_pages,
   output logic             mem_re,
   output logic [DWA_W-1:0] mem_addr,
   input  logic [63:0]      mem_rdata,
   output logic             irq
);
   localparam int BA_W   = DWA_W + 3;
   localparam int LEN_LO = 32 - LEN_W;

   logic             lock_q, cmd_q, ie_q, end_q, prot_q, align_q, res_q;
   logic [LEN_W-1:0] len_q;
   logic [BA_W-1:0]  base_q;
   logic             scan_busy, scan_done, scan_dirty, unlock_pls, range_bad;

   logic word_ok, wr_key, wr_stat, wr_ctrl, wr_addr;
   assign word_ok = (bus_size == SZ_WORD);
   assign wr_key  = bus_wr && word_ok && (bus_addr == OFS_KEY);
   assign wr_stat = bus_wr && word_ok && (bus_addr == OFS_STAT);
   assign wr_ctrl = bus_wr && word_ok && (bus_addr == OFS_CTRL);
   assign wr_addr = bus_wr && word_ok && (bus_addr == OFS_ADDR);

   logic [LEN_W-1:0] len_wr;
   logic             go_req, misaligned, start_ok;
   assign len_wr     = bus_wdata[31 -: LEN_W];
   assign go_req     = wr_ctrl && !lock_q && !scan_busy && bus_wdata[CB_CMD] && bus_wdata[CB_GO];
   assign misaligned = |base_q[2:0];
   assign start_ok   = go_req && !misaligned && !range_bad;

   bscan_key u_key (
      .clk(clk), .rst_n(rst_n), .key_wr(wr_key), .key_data(bus_wdata), .unlock(unlock_pls)
   );

   bscan_guard #(.FLASH_DW(FLASH_DW), .PAGE_DW(PAGE_DW), .LEN_W(LEN_W)) u_guard (
      .start_dw(base_q[BA_W-1:3]), .len_code(len_wr), .wp(wp_pages), .blocked(range_bad)
   );

   bscan_engine #(.FLASH_DW(FLASH_DW), .LEN_W(LEN_W), .DATA_W(64), .IN_REG(IN_REG)) u_engine (
      .clk(clk), .rst_n(rst_n), .start(start_ok), .start_dw(base_q[BA_W-1:3]),
      .len_code(len_wr), .mem_re(mem_re), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .busy(scan_busy), .done(scan_done), .dirty(scan_dirty)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q  <= 1'b1;
         cmd_q   <= 1'b0;
         ie_q    <= 1'b0;
         len_q   <= '0;
         base_q  <= '0;
      end else begin
         if (unlock_pls) lock_q <= 1'b0;
         if (wr_ctrl) begin
            if (bus_wdata[CB_LOCK]) lock_q <= 1'b1;
            if (!lock_q) begin
               ie_q <= bus_wdata[CB_IE];
               if (!scan_busy) begin
                  cmd_q <= bus_wdata[CB_CMD];
                  len_q <= len_wr;
               end
            end
         end
         if (wr_addr && !scan_busy) base_q <= bus_wdata[BA_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         end_q   <= 1'b0;
         prot_q  <= 1'b0;
         align_q <= 1'b0;
         res_q   <= 1'b0;
      end else begin
         if (wr_stat && bus_wdata[SB_END])   end_q   <= 1'b0;
         if (wr_stat && bus_wdata[SB_PROT])  prot_q  <= 1'b0;
         if (wr_stat && bus_wdata[SB_ALIGN]) align_q <= 1'b0;
         if (scan_done)                      end_q   <= 1'b1;
         if (go_req && misaligned)           align_q <= 1'b1;
         if (go_req && !misaligned && range_bad) prot_q <= 1'b1;
         if (start_ok)        res_q <= 1'b0;
         else if (scan_dirty) res_q <= 1'b1;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (word_ok) begin
         unique case (bus_addr)
            OFS_STAT: begin
               bus_rdata[SB_BUSY]  = scan_busy;
               bus_rdata[SB_END]   = end_q;
               bus_rdata[SB_PROT]  = prot_q;
               bus_rdata[SB_ALIGN] = align_q;
               bus_rdata[SB_RES]   = res_q;
            end
            OFS_CTRL: begin
               bus_rdata[31 -: LEN_W] = len_q;
               bus_rdata[CB_LOCK]     = lock_q;
               bus_rdata[CB_IE]       = ie_q;
               bus_rdata[CB_CMD]      = cmd_q;
            end
            OFS_ADDR: bus_rdata[BA_W-1:0] = base_q;
            default:  bus_rdata = '0;
         endcase
      end
   end

   assign irq = ie_q & end_q;

   initial begin
      AST_CFG_LEN: assert (LEN_W >= 1 && LEN_W <= 4 && LEN_LO > CB_LOCK)
         else $error("LEN_W out of range");
      AST_CFG_FLASH_POW2: assert (FLASH_DW >= 2 && (FLASH_DW & (FLASH_DW - 1)) == 0)
         else $error("FLASH_DW must be a power of two");
   end

   AST_UNLOCK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      unlock_pls |=> !lock_q); // R2
   AST_LOCKED_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> $stable(len_q) && $stable(cmd_q) && $stable(ie_q)); // R3
   AST_LOCKED_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && !scan_busy) |=> !scan_busy); // R3
   AST_END_FROM_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(end_q) |-> $past(scan_busy)); // R8
   AST_BUSY_TO_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scan_busy) |-> end_q); // R8
   AST_END_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (end_q && !(wr_stat && bus_wdata[SB_END])) |=> end_q); // R8
   AST_PROT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (go_req && range_bad) |=> !scan_busy && !mem_re); // R9
   AST_ALIGN_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (go_req && misaligned) |=> !scan_busy && !prot_q); // R10
   AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!scan_busy && !start_ok) |=> $stable(res_q)); // R7
   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !wr_stat && !wr_ctrl) |=> irq); // R11
endmodule

// File: tb/tb_bscan_blank_check.sv
module tb_bscan_blank_check;
   localparam int FLASH_DW = 256;
   localparam int PAGE_DW  = 16;
   localparam int NPAGE    = FLASH_DW / PAGE_DW;
   localparam logic [3:0] A_KEY = 4'h0, A_STAT = 4'h4, A_CTRL = 4'h8, A_ADDR = 4'hC;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [1:0]  bus_size = 2'b10;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NPAGE-1:0] wp_pages = '0;
   logic        mem_re;
   logic [7:0]  mem_addr;
   logic [63:0] mem_rdata = '0;
   logic        irq;

   always #5 clk = ~clk;

   bscan_blank_check #(.FLASH_DW(FLASH_DW), .PAGE_DW(PAGE_DW), .LEN_W(3), .IN_REG(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_size(bus_size),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wp_pages(wp_pages), .mem_re(mem_re),
      .mem_addr(mem_addr), .mem_rdata(mem_rdata), .irq(irq)
   );

   logic [63:0] mem [FLASH_DW];
   logic [7:0]  rd_log [1024];
   int          rd_cnt = 0;
   int          n_chk = 0;
   int          n_fail = 0;

   always @(posedge clk) begin
      if (mem_re) begin
         mem_rdata <= mem[mem_addr];
         rd_log[rd_cnt % 1024] <= mem_addr;
         rd_cnt <= rd_cnt + 1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [1:0] sz = 2'b10);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
      @(negedge clk);
      bus_wr = 1'b0; bus_size = 2'b10;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d, input logic [1:0] sz = 2'b10);
      bus_addr = a; bus_size = sz;
      #1 d = bus_rdata;
      bus_size = 2'b10;
   endtask

   function automatic logic [31:0] go(input int len, input bit ie);
      return (32'(len) << 29) | 32'h3 | (ie ? 32'h4 : 32'h0);
   endfunction

   task automatic wait_idle();
      logic [31:0] s;
      for (int i = 0; i < 3000; i++) begin
         rd(A_STAT, s);
         if (!s[0]) break;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(A_CTRL, v); chk("R1 ctrl", v, 32'h80);
      rd(A_STAT, v); chk("R1 stat", v, 32'h0);
      rd(A_ADDR, v); chk("R1 addr", v, 32'h0);
      chk("R1 irq", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_locked();
      logic [31:0] v; int base;
      base = rd_cnt;
      wr(A_CTRL, go(2, 1'b1));
      rd(A_CTRL, v); chk("R3 ctrl unchanged", v, 32'h80);
      repeat (10) @(negedge clk);
      rd(A_STAT, v); chk("R3 no start", v, 32'h0);
      chk("R3 no reads", 32'(rd_cnt - base), 32'h0);
      wr(A_KEY, 32'hCDEF_89AB); wr(A_KEY, 32'h4567_0123); wr(A_KEY, 32'h1234_5678);
      wr(A_KEY, 32'hCDEF_89AB);
      rd(A_CTRL, v); chk("R2 wrong order stays locked", v, 32'h80);
      wr(A_KEY, 32'h4567_0123); wr(A_KEY, 32'hCDEF_89AB);
      rd(A_CTRL, v); chk("R2 unlocked", v, 32'h0);
   endtask

   task automatic t_width();
      logic [31:0] v;
      wr(A_CTRL, 32'h4, 2'b01);
      rd(A_CTRL, v); chk("R4 half write ignored", v, 32'h0);
      wr(A_CTRL, 32'h4);
      rd(A_CTRL, v, 2'b00); chk("R4 byte read zero", v, 32'h0);
      rd(A_CTRL, v); chk("R4 word read", v, 32'h4);
      wr(A_CTRL, 32'h0);
   endtask

   task automatic t_blank();
      logic [31:0] v; int base; bit asc;
      base = rd_cnt;
      wr(A_ADDR, 32'h40);
      wr(A_CTRL, go(2, 1'b0));
      rd(A_CTRL, v); chk("R5 go self-clears", v, 32'h4000_0001);
      rd(A_STAT, v); chk("R5 busy", v & 32'h1, 32'h1);
      wait_idle();
      rd(A_STAT, v); chk("R8 R7 end and blank", v, 32'h02);
      chk("R6 read count", 32'(rd_cnt - base), 32'd4);
      chk("R6 first index", 32'(rd_log[base % 1024]), 32'd8);
      asc = 1'b1;
      for (int i = 1; i < 4; i++)
         if (rd_log[(base + i) % 1024] != rd_log[(base + i - 1) % 1024] + 8'd1) asc = 1'b0;
      chk("R6 ascending", {31'b0, asc}, 32'h1);
      chk("R11 no irq when disabled", {31'b0, irq}, 32'h0);
      wr(A_STAT, 32'h0);
      rd(A_STAT, v); chk("R8 write 0 keeps end", v, 32'h02);
      wr(A_STAT, 32'h2);
      rd(A_STAT, v); chk("R8 w1c end", v, 32'h0);
   endtask

   task automatic t_dirty();
      logic [31:0] v; int base;
      base = rd_cnt;
      mem[20][15:8] = 8'h7F;
      wr(A_ADDR, 32'(16 * 8));
      wr(A_CTRL, go(3, 1'b0));
      wait_idle();
      rd(A_STAT, v); chk("R7 not blank", v, 32'h12);
      chk("R7 early stop count", 32'(rd_cnt - base), 32'd5);
      chk("R7 stop index", 32'(rd_log[(rd_cnt - 1) % 1024]), 32'd20);
      mem[20] = '1;
      wr(A_STAT, 32'h1E);
      wr(A_CTRL, go(0, 1'b0));
      wait_idle();
      rd(A_STAT, v); chk("R7 result cleared on new check", v, 32'h02);
      wr(A_STAT, 32'h1E);
   endtask

   task automatic t_irq();
      logic [31:0] v;
      wr(A_ADDR, 32'h0);
      wr(A_CTRL, go(0, 1'b1));
      wait_idle();
      chk("R11 irq raised", {31'b0, irq}, 32'h1);
      repeat (8) @(negedge clk);
      chk("R11 irq held", {31'b0, irq}, 32'h1);
      wr(A_STAT, 32'h2);
      chk("R11 irq drops", {31'b0, irq}, 32'h0);
      wr(A_CTRL, 32'h0);
      rd(A_STAT, v); chk("R8 idle after irq test", v, 32'h0);
   endtask

   task automatic t_prot();
      logic [31:0] v; int base;
      wp_pages = 16'h0008;
      base = rd_cnt;
      wr(A_ADDR, 32'(40 * 8));
      wr(A_CTRL, go(4, 1'b0));
      rd(A_STAT, v); chk("R9 prot flag", v, 32'h04);
      repeat (10) @(negedge clk);
      chk("R9 no reads", 32'(rd_cnt - base), 32'h0);
      wr(A_STAT, 32'h4);
      rd(A_STAT, v); chk("R9 w1c prot", v, 32'h0);
      wr(A_CTRL, go(3, 1'b0));
      wait_idle();
      rd(A_STAT, v); chk("R9 adjacent page allowed", v, 32'h02);
      wr(A_STAT, 32'h1E);
      wp_pages = '0;
      base = rd_cnt;
      wr(A_ADDR, 32'(200 * 8));
      wr(A_CTRL, go(7, 1'b0));
      rd(A_STAT, v); chk("R9 overrun rejected", v, 32'h04);
      chk("R9 overrun no reads", 32'(rd_cnt - base), 32'h0);
      wr(A_STAT, 32'h1E);
      base = rd_cnt;
      wr(A_ADDR, 32'(128 * 8));
      wr(A_CTRL, go(7, 1'b0));
      wait_idle();
      rd(A_STAT, v); chk("R6 full span", v, 32'h02);
      chk("R6 128 reads", 32'(rd_cnt - base), 32'd128);
      chk("R6 last index", 32'(rd_log[(rd_cnt - 1) % 1024]), 32'd255);
      wr(A_STAT, 32'h1E);
   endtask

   task automatic t_align();
      logic [31:0] v; int base;
      base = rd_cnt;
      wr(A_ADDR, 32'h44);
      wr(A_CTRL, go(0, 1'b0));
      rd(A_STAT, v); chk("R10 align flag", v, 32'h08);
      chk("R10 no reads", 32'(rd_cnt - base), 32'h0);
      wr(A_STAT, 32'h8);
      rd(A_STAT, v); chk("R10 w1c align", v, 32'h0);
      wp_pages = 16'h0001;
      wr(A_ADDR, 32'h4);
      wr(A_CTRL, go(0, 1'b0));
      rd(A_STAT, v); chk("R10 priority over prot", v, 32'h08);
      wr(A_STAT, 32'h1E);
      wp_pages = '0;
   endtask

   task automatic t_relock();
      logic [31:0] v; int base;
      wr(A_CTRL, 32'h80);
      rd(A_CTRL, v); chk("R2 relocked", v, 32'h80);
      wr(A_ADDR, 32'h0);
      base = rd_cnt;
      wr(A_CTRL, go(1, 1'b0));
      repeat (6) @(negedge clk);
      chk("R3 relocked no reads", 32'(rd_cnt - base), 32'h0);
   endtask

   initial begin
      for (int i = 0; i < FLASH_DW; i++) mem[i] = '1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_locked();
      t_width();
      t_blank();
      t_dirty();
      t_irq();
      t_prot();
      t_align();
      t_relock();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      #1_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule